// File: doc/BRIEF.md
# Dual programmable bit-rate clock-enable generator

This block derives two independent bit-rate strobes, one for the receive side and one for the transmit side of a serial channel, from a single base clock. Each side divides the base clock by the product of an 8-bit time constant and a power of two chosen by an exponent field. Its output is a one-cycle enable pulse at the resulting rate. The serializer and deserializer next to it use this pulse as a clock enable.

Both sides are set through a small write-only register port. The divide ratio of a side is `N = T * 2^E`, where `T` is its time constant (a stored zero counts as 256) and `E` is its exponent. Each side keeps one down-counter. When the counter reaches terminal count, the side fires its pulse and reloads from the settings current at that edge. New settings therefore change the following period and never cut short the period that is running.

Top module: `brg_dual`

## Requirements
- R1: Once settings are stable, a side's enable pulses repeat every `N = T * 2^E` base-clock cycles.
- R2: A stored time constant of 0 acts as 256, so with `E = 0` the period is 256 cycles.
- R3: The exponent ranges from 0 to `MAX_EXP`. An exponent write with a data value above `MAX_EXP` stores `MAX_EXP`.
- R4: With `T = 1` and `E = 0` the enable output is high on every cycle.
- R5: Writing one side's registers leaves the other side's pulse period unchanged.
- R6: A register write in the middle of a period does not change the length of that period. The new ratio applies from the next reload.
- R7: While `rst` is high both enables are low, and the registers return to `T = 0` and `E = MAX_EXP`. Count the first rising edge with `rst` low as edge 0. The first pulse is registered at edge `N`.
- R8: When `N >= 2`, each pulse is high for exactly one cycle.
- R9: Register map, written when `wr_en` is high: address 0 is the receive time constant, 1 the receive exponent, 2 the transmit time constant, 3 the transmit exponent. The exponent compares the full `wr_data` value against `MAX_EXP` before storing its low `EXP_W` bits.
- R10: The gap between two pulses of one side never exceeds `256 * 2^MAX_EXP` cycles in steady operation. The gap from reset release to the first pulse never exceeds `256 * 2^MAX_EXP + 1` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (see R9) |
| wr_data | input | DATA_W | Write data |
| rx_tick | output | 1 | Receive-side bit-rate enable |
| tx_tick | output | 1 | Transmit-side bit-rate enable |

## Verification
The bench builds the block with `MAX_EXP = 3` instead of the default 9 and keeps the full 8-bit time constant. The slowest ratio, a zero time constant with the top exponent, is then 2048 cycles. That puts the post-reset default period and the longest divide within a short run. It also makes exponent saturation reachable, because ordinary writes such as 9 or 15 exceed the limit.

// File: rtl/brg_pkg.sv
`timescale 1ns/1ps
package brg_pkg;
  localparam int NUM_SIDES = 2;
  localparam int SIDE_RX   = 0;
  localparam int SIDE_TX   = 1;

  // Register select; a side's pair sits at 2*side and 2*side+1
  typedef enum logic [1:0] {
    REG_RX_TC  = 2'd0,
    REG_RX_EXP = 2'd1,
    REG_TX_TC  = 2'd2,
    REG_TX_EXP = 2'd3
  } brg_reg_e;
endpackage

// File: rtl/brg_reg_bank.sv
`timescale 1ns/1ps
module brg_reg_bank
  import brg_pkg::*;
#(
  parameter int TC_W    = 8,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 9,
  parameter int DATA_W  = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [1:0]                          wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_SIDES-1:0][TC_W-1:0]      tc_o,
  output logic [NUM_SIDES-1:0][EXP_W-1:0]     exp_o
);
  localparam logic [EXP_W-1:0]  EXP_RST = EXP_W'(MAX_EXP);
  localparam logic [DATA_W-1:0] EXP_LIM = DATA_W'(MAX_EXP);

  logic [EXP_W-1:0] exp_clamped;
  logic [TC_W-1:0]  tc_wdata;

  // Saturate out-of-range exponent writes
  always_comb begin
    if (wr_data > EXP_LIM) exp_clamped = EXP_RST;
    else                   exp_clamped = wr_data[EXP_W-1:0];
    tc_wdata = wr_data[TC_W-1:0];
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam brg_reg_e TC_SEL  = brg_reg_e'(2 * s);
    localparam brg_reg_e EXP_SEL = brg_reg_e'(2 * s + 1);

    logic [TC_W-1:0]  tc_r;
    logic [EXP_W-1:0] exp_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        tc_r  <= '0;
        exp_r <= EXP_RST;
      end else if (wr_en) begin
        if (wr_addr == TC_SEL)  tc_r  <= tc_wdata;
        if (wr_addr == EXP_SEL) exp_r <= exp_clamped;
      end
    end

    assign tc_o[s]  = tc_r;
    assign exp_o[s] = exp_r;
  end
endmodule

// File: rtl/brg_reload_calc.sv
`timescale 1ns/1ps
module brg_reload_calc #(
  parameter int TC_W    = 8,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 9,
  parameter int CNT_W   = TC_W + MAX_EXP
) (
  input  logic [TC_W-1:0]  tc_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [CNT_W-1:0] reload_o
);
  // N-1 = (T-1)*2^E + (2^E - 1); T-1 wraps so that T=0 behaves as 2^TC_W
  logic [TC_W-1:0]  tc_m1;
  logic [CNT_W-1:0] low_mask;

  always_comb begin
    tc_m1    = tc_i - TC_W'(1);
    low_mask = (CNT_W'(1) << exp_i) - CNT_W'(1);
    reload_o = (CNT_W'(tc_m1) << exp_i) | low_mask;
  end
endmodule

// File: rtl/brg_divider.sv
`timescale 1ns/1ps
module brg_divider #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o
);
  logic             primed;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (!primed) begin
      primed <= 1'b1;
      cnt    <= reload_i;
      tick_o <= 1'b0;
    end else if (cnt == '0) begin
      cnt    <= reload_i;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt - CNT_W'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/brg_dual.sv
`timescale 1ns/1ps
module brg_dual
  import brg_pkg::*;
#(
  parameter int TC_W    = 8,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 9,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rx_tick,
  output logic              tx_tick
);
  localparam int CNT_W = TC_W + MAX_EXP;

  logic [NUM_SIDES-1:0][TC_W-1:0]  tc_q;
  logic [NUM_SIDES-1:0][EXP_W-1:0] exp_q;
  logic [NUM_SIDES-1:0]            tick;

  brg_reg_bank #(
    .TC_W(TC_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tc_o(tc_q), .exp_o(exp_q)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_chan
    logic [CNT_W-1:0] reload;

    brg_reload_calc #(
      .TC_W(TC_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .CNT_W(CNT_W)
    ) calc_i (
      .tc_i(tc_q[s]), .exp_i(exp_q[s]), .reload_o(reload)
    );

    brg_divider #(.CNT_W(CNT_W)) div_i (
      .clk(clk), .rst(rst), .reload_i(reload), .tick_o(tick[s])
    );
  end

  assign rx_tick = tick[SIDE_RX];
  assign tx_tick = tick[SIDE_TX];
endmodule

// File: rtl/brg_dual_chk.sv
`timescale 1ns/1ps
module brg_dual_chk
  import brg_pkg::*;
#(
  parameter int TC_W    = 8,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 9
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            rx_tick,
  input logic                            tx_tick,
  input logic [NUM_SIDES-1:0][TC_W-1:0]  tc_q,
  input logic [NUM_SIDES-1:0][EXP_W-1:0] exp_q
);
  localparam int MAX_RATIO = (2 ** TC_W) * (2 ** MAX_EXP);

  logic [NUM_SIDES-1:0] ticks;
  logic                 rst_d;

  assign ticks = {tx_tick, rx_tick};

  always_ff @(posedge clk) begin
    rst_d <= rst;
    // R7
    if (rst_d) begin
      reset_quiet_chk: assert (ticks == '0)
        else $error("enable high after a reset cycle");
    end
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    int gap;

    always_ff @(posedge clk) begin
      if (rst)           gap <= 0;
      else if (ticks[s]) gap <= 1;
      else               gap <= gap + 1;
    end

    // R10
    gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
      gap <= MAX_RATIO + 1)
      else $error("pulse gap exceeds slowest ratio");

    // R3
    exp_range_chk: assert property (@(posedge clk) disable iff (rst)
      exp_q[s] <= EXP_W'(MAX_EXP))
      else $error("stored exponent above limit");

    // R4
    ratio_one_chk: assert property (@(posedge clk) disable iff (rst)
      (ticks[s] && tc_q[s] == TC_W'(1) && exp_q[s] == '0 &&
       $stable(tc_q[s]) && $stable(exp_q[s])) |=> ticks[s])
      else $error("divide-by-one enable dropped");

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (ticks[s] && !(tc_q[s] == TC_W'(1) && exp_q[s] == '0) &&
       $stable(tc_q[s]) && $stable(exp_q[s])) |=> !ticks[s])
      else $error("enable wider than one cycle");
  end
endmodule

bind brg_dual brg_dual_chk #(
  .TC_W(TC_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)
) chk_i (
  .clk(clk), .rst(rst), .rx_tick(rx_tick), .tx_tick(tx_tick),
  .tc_q(tc_q), .exp_q(exp_q)
);

// File: tb/brg_dual_tb_top.sv
`timescale 1ns/1ps
module brg_dual_tb_top;
  localparam int TC_W    = 8;
  localparam int EXP_W   = 4;
  localparam int MAX_EXP = 3;
  localparam int DATA_W  = 8;
  localparam int DEF_N   = 256 * 8;   // reset settings: T=0, E=MAX_EXP

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst;
  logic              wr_en;
  logic [1:0]        wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              rx_tick;
  logic              tx_tick;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  brg_dual #(
    .TC_W(TC_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .DATA_W(DATA_W)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_tick(rx_tick), .tx_tick(tx_tick)
  );

  // rx_T, rx_E, tx_T, tx_E, expected rx period, expected tx period
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{  1, 0,  2,  0,   1,    2},
    '{  5, 1,  1,  3,  10,    8},
    '{  0, 0,  3,  2, 256,   12},
    '{  7, 9,  1, 15,  56,    8},
    '{255, 1,  0,  3, 510, 2048},
    '{  2, 3,  1,  0,  16,    1}
  };
  localparam string TAGS [NV] = '{"R1 R4", "R1", "R2 R1", "R3", "R2 R10", "R1 R4"};

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic logic tk(input bit side);
    return side ? tx_tick : rx_tick;
  endfunction

  // Wait for the next pulse, then count cycles to the one after it
  task automatic measure(input bit side, output int n);
    do @(negedge clk); while (!tk(side));
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tk(side));
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic first_pulse(output int rx_n, output int tx_n);
    int n;
    rx_n = 0; tx_n = 0; n = 0;
    while ((rx_n == 0 || tx_n == 0) && n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rx_tick && rx_n == 0) rx_n = n;
      if (tx_tick && tx_n == 0) tx_n = n;
    end
  endtask

  initial begin
    int n, a, b, highs;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    // R7: quiet during reset
    repeat (4) begin
      @(negedge clk);
      check("R7 low in reset", int'(rx_tick | tx_tick), 0);
    end
    rst = 1'b0;
    // R7, R10: first pulse after N edges from edge 0 with default settings
    first_pulse(a, b);
    check("R7 rx first pulse", a, DEF_N + 1);
    check("R7 tx first pulse", b, DEF_N + 1);

    // Table walk: R1, R2, R3, R4, R9, R10
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i][0]);
      wr(2'd1, VEC[i][1]);
      wr(2'd2, VEC[i][2]);
      wr(2'd3, VEC[i][3]);
      for (int s = 0; s < 2; s++) begin
        measure(s[0], n);
        measure(s[0], n);
        check($sformatf("%s R9 vec%0d side%0d", TAGS[i], i, s), n, VEC[i][4 + s]);
      end
    end

    // R4: divide by one stays high
    wr(2'd0, 1); wr(2'd1, 0);
    measure(1'b0, n);
    highs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (rx_tick) highs++;
    end
    check("R4 rx high every cycle", highs, 20);

    // R5: transmit unaffected by receive writes
    wr(2'd2, 4); wr(2'd3, 0);
    measure(1'b1, n);
    wr(2'd0, 9); wr(2'd1, 2);
    measure(1'b1, n);
    check("R5 tx period during rx writes", n, 4);
    measure(1'b1, n);
    check("R5 tx period after rx writes", n, 4);

    // R6: mid-period write does not shorten the running period
    wr(2'd0, 40); wr(2'd1, 0);
    measure(1'b0, n);
    measure(1'b0, n);
    check("R6 R1 rx steady period", n, 40);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 5) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = DATA_W'(3);
      end
      if (n == 6) wr_en = 1'b0;
    end while (!rx_tick && n < 1000);
    check("R6 running period kept", n, 40);
    measure(1'b0, n);
    check("R6 new period after reload", n, 3);

    // R8: one-cycle pulse at ratio 3
    do @(negedge clk); while (!rx_tick);
    @(negedge clk);
    check("R8 pulse width", int'(rx_tick), 0);

    // R7: reset during operation restores defaults
    wr(2'd0, 1); wr(2'd1, 0);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R7 low after mid-run reset", int'(rx_tick | tx_tick), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    first_pulse(a, b);
    check("R7 rx defaults restored", a, DEF_N + 1);
    check("R7 tx defaults restored", b, DEF_N + 1);

    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual 1 expected 0");
      finish_run();
    end
  end
endmodule